// File: doc/BRIEF.md
# Filter interrupt status controller

This block gathers the event pulses produced by one filter path of a sigma-delta front end and turns them into sticky status flags. It also keeps the enables for those flags and drives a single combined interrupt request. The filtering, the threshold comparison and the clock monitoring are done elsewhere. They arrive here as single-cycle pulses: two conversion-done events, two overrun events, a watchdog summary event, and two per-channel vectors, one for short-circuit detection and one for missing clock.

Software reaches the block through a plain register port. A read is strobed with `bus_rd_i` and its data appears one cycle later, marked by `bus_rvalid_o`. There is no back-pressure: every strobed read returns data on the next cycle, and a write takes effect at the edge where `bus_wr_i` is sampled. The two conversion-done flags clear when software reads the matching data register. All other flags clear only when software writes a 1 to the matching bit of the clear register.

Top module: `fltirq_ctrl`

## Requirements
- R1: After reset, every flag, every enable bit and every per-channel enable bit is 0, `irq_o` is 0 and `bus_rvalid_o` is 0.
- R2: An `evt_inj_done_i` pulse sets STATUS bit 0. A read of address 4 (injected data) returns `inj_data_i`, zero-extended, and clears that flag. The flag's interrupt is gated by ENABLE bit 0.
- R3: An `evt_reg_done_i` pulse sets STATUS bit 1. A read of address 5 (regular data) returns `reg_data_i`, zero-extended, and clears that flag. The flag's interrupt is gated by ENABLE bit 1.
- R4: The injected and regular overrun flags (STATUS bits 2 and 3) clear only when a 1 is written to bit 2 or bit 3 of CLEAR (address 3). Data-register reads leave them set. Their interrupts are gated by ENABLE bits 2 and 3.
- R5: The watchdog flag is STATUS bit 4. It clears when a 1 is written to CLEAR bit 4, and its interrupt is gated by ENABLE bit 4.
- R6: Short-circuit flag `c` is STATUS bit 8+c. It is set by `evt_short_i[c]` only while CHAN_EN (address 2) bit c is 1, and it clears when a 1 is written to CLEAR bit 8+c. Any short-circuit flag interrupts while ENABLE bit 5 is 1.
- R7: Clock-absence flag `c` is STATUS bit 16+c. It is set by `evt_clkloss_i[c]` regardless of the enables, and it clears when a 1 is written to CLEAR bit 16+c. It interrupts only while both ENABLE bit 6 and CHAN_EN bit 8+c are 1.
- R8: When an event pulse and a clear of the same flag fall in the same cycle, whether the clear is a CLEAR write or a data-register read, the flag ends up set.
- R9: `irq_o` is a register holding the OR of all enabled flags. It rises one cycle after a flag or enable edge makes the OR true, and it falls one cycle after the OR becomes false.
- R10: Zero bits written to CLEAR change nothing, and reading STATUS (address 0) leaves every flag unchanged.
- R11: `bus_rvalid_o` is high exactly one cycle after each `bus_rd_i` strobe. ENABLE (address 1, bits 6:0) and CHAN_EN (bits 7:0 short-circuit, bits 15:8 clock absence) read back as written, and reads of CLEAR or of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_inj_done_i | input | 1 | Injected conversion finished pulse |
| evt_reg_done_i | input | 1 | Regular conversion finished pulse |
| evt_inj_ovr_i | input | 1 | Injected overrun pulse |
| evt_reg_ovr_i | input | 1 | Regular overrun pulse |
| evt_wdog_i | input | 1 | Watchdog threshold crossing pulse |
| evt_short_i | input | NCH | Per-channel short-circuit pulses |
| evt_clkloss_i | input | NCH | Per-channel clock-absence pulses |
| inj_data_i | input | DW | Current injected conversion result |
| reg_data_i | input | DW | Current regular conversion result |
| bus_addr_i | input | 3 | Register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | BW | Write data |
| bus_rd_i | input | 1 | Read strobe |
| bus_rdata_o | output | BW | Read data, valid with bus_rvalid_o |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after bus_rd_i |
| irq_o | output | 1 | Combined registered interrupt request |

## Verification
The assertions check the following on every cycle: an overrun flag stays set until it is explicitly cleared; a set pulse always wins; a read of the injected data register clears its flag; a short-circuit flag never rises on a channel whose detector is disabled; a status read never disturbs the flags; and each read strobe yields exactly one valid response. The bench scenarios cover the rest. They check the returned data values, the cycle in which the interrupt rises and falls under each gating combination, the clock-absence double qualification, and the fact that writing zeros to the clear register has no effect.

// File: rtl/fltirq_pkg.sv
package fltirq_pkg;
  localparam int unsigned ADDR_W     = 3;
  localparam int unsigned NUM_SCALAR = 5;
  localparam int unsigned IDX_INJ_DONE = 0;
  localparam int unsigned IDX_REG_DONE = 1;
  localparam int unsigned IDX_INJ_OVR  = 2;
  localparam int unsigned IDX_REG_OVR  = 3;
  localparam int unsigned IDX_WDOG     = 4;
  // field positions in STATUS / CLEAR words
  localparam int unsigned SHORT_LSB = 8;
  localparam int unsigned CLK_LSB   = 16;
  // ENABLE register
  localparam int unsigned EN_SHORT = 5;
  localparam int unsigned EN_CLK   = 6;
  localparam int unsigned EN_W     = 7;
  // CHAN_EN register: short-circuit enables at bit 0, clock-absence at this LSB
  localparam int unsigned CK_EN_LSB = 8;

  typedef enum logic [ADDR_W-1:0] {
    A_STATUS   = 3'd0,
    A_ENABLE   = 3'd1,
    A_CHAN_EN  = 3'd2,
    A_CLEAR    = 3'd3,
    A_INJ_DATA = 3'd4,
    A_REG_DATA = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/fltirq_flags.sv
// Bank of sticky flags: a set request has priority over a clear request.
module fltirq_flags #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_q
);
  for (genvar i = 0; i < W; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flag_q[i] <= 1'b0;
      end else if (set_i[i]) begin
        flag_q[i] <= 1'b1;
      end else if (clr_i[i]) begin
        flag_q[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fltirq_regs.sv
// Register port: enable storage, clear decode and registered read mux.
module fltirq_regs
  import fltirq_pkg::*;
#(
  parameter int unsigned NCH = 8,
  parameter int unsigned DW  = 24,
  parameter int unsigned BW  = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  wr_i,
  input  logic [BW-1:0]         wdata_i,
  input  logic                  rd_i,
  input  logic [NUM_SCALAR-1:0] scalar_flags_i,
  input  logic [NCH-1:0]        short_flags_i,
  input  logic [NCH-1:0]        clk_flags_i,
  input  logic [DW-1:0]         inj_data_i,
  input  logic [DW-1:0]         reg_data_i,
  output logic [EN_W-1:0]       en_q,
  output logic [NCH-1:0]        sc_chan_en_q,
  output logic [NCH-1:0]        ck_chan_en_q,
  output logic [NUM_SCALAR-1:0] w1c_scalar,
  output logic [NCH-1:0]        w1c_short,
  output logic [NCH-1:0]        w1c_clk,
  output logic                  rdclr_inj,
  output logic                  rdclr_reg,
  output logic [BW-1:0]         rdata_q,
  output logic                  rvalid_q
);
  localparam int unsigned USED_W = CLK_LSB + NCH;

  logic          wr_clr;
  logic [BW-1:0] rd_next;
  logic          unused_wdata;

  assign unused_wdata = ^wdata_i[BW-1:USED_W];

  assign wr_clr = wr_i && (addr_i == A_CLEAR);

  // conversion-done flags clear only through data reads
  always_comb begin
    w1c_scalar = '0;
    if (wr_clr) begin
      w1c_scalar[IDX_INJ_OVR] = wdata_i[IDX_INJ_OVR];
      w1c_scalar[IDX_REG_OVR] = wdata_i[IDX_REG_OVR];
      w1c_scalar[IDX_WDOG]    = wdata_i[IDX_WDOG];
    end
  end

  assign w1c_short = wr_clr ? wdata_i[SHORT_LSB +: NCH] : '0;
  assign w1c_clk   = wr_clr ? wdata_i[CLK_LSB +: NCH]   : '0;
  assign rdclr_inj = rd_i && (addr_i == A_INJ_DATA);
  assign rdclr_reg = rd_i && (addr_i == A_REG_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q         <= '0;
      sc_chan_en_q <= '0;
      ck_chan_en_q <= '0;
    end else if (wr_i) begin
      if (addr_i == A_ENABLE) begin
        en_q <= wdata_i[EN_W-1:0];
      end
      if (addr_i == A_CHAN_EN) begin
        sc_chan_en_q <= wdata_i[0 +: NCH];
        ck_chan_en_q <= wdata_i[CK_EN_LSB +: NCH];
      end
    end
  end

  always_comb begin
    rd_next = '0;
    case (addr_i)
      A_STATUS: begin
        rd_next[NUM_SCALAR-1:0]     = scalar_flags_i;
        rd_next[SHORT_LSB +: NCH]   = short_flags_i;
        rd_next[CLK_LSB +: NCH]     = clk_flags_i;
      end
      A_ENABLE:   rd_next[EN_W-1:0] = en_q;
      A_CHAN_EN: begin
        rd_next[0 +: NCH]           = sc_chan_en_q;
        rd_next[CK_EN_LSB +: NCH]   = ck_chan_en_q;
      end
      A_INJ_DATA: rd_next[DW-1:0]   = inj_data_i;
      A_REG_DATA: rd_next[DW-1:0]   = reg_data_i;
      default:    rd_next           = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_i;
      if (rd_i) begin
        rdata_q <= rd_next;
      end
    end
  end
endmodule

// File: rtl/fltirq_irq.sv
// Per-flag enable mask and registered interrupt combine.
module fltirq_irq
  import fltirq_pkg::*;
#(
  parameter int unsigned NCH = 8,
  localparam int unsigned NF = NUM_SCALAR + 2 * NCH
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NF-1:0]   flags_i,
  input  logic [EN_W-1:0] en_i,
  input  logic [NCH-1:0]  ck_chan_en_i,
  output logic            irq_q
);
  logic [NF-1:0] mask;
  logic          irq_d;

  assign mask = {ck_chan_en_i & {NCH{en_i[EN_CLK]}},
                 {NCH{en_i[EN_SHORT]}},
                 en_i[NUM_SCALAR-1:0]};

  assign irq_d = |(flags_i & mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end
endmodule

// File: rtl/fltirq_ctrl.sv
// Filter interrupt status controller top.
module fltirq_ctrl
  import fltirq_pkg::*;
#(
  parameter int unsigned NCH = 8,
  parameter int unsigned DW  = 24,
  parameter int unsigned BW  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_inj_done_i,
  input  logic              evt_reg_done_i,
  input  logic              evt_inj_ovr_i,
  input  logic              evt_reg_ovr_i,
  input  logic              evt_wdog_i,
  input  logic [NCH-1:0]    evt_short_i,
  input  logic [NCH-1:0]    evt_clkloss_i,
  input  logic [DW-1:0]     inj_data_i,
  input  logic [DW-1:0]     reg_data_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [BW-1:0]     bus_wdata_i,
  input  logic              bus_rd_i,
  output logic [BW-1:0]     bus_rdata_o,
  output logic              bus_rvalid_o,
  output logic              irq_o
);
  localparam int unsigned NF      = NUM_SCALAR + 2 * NCH;
  localparam int unsigned SC_BASE = NUM_SCALAR;
  localparam int unsigned CK_BASE = NUM_SCALAR + NCH;

  logic [NF-1:0]         flags_q;
  logic [NF-1:0]         set_vec;
  logic [NF-1:0]         clr_vec;
  logic [EN_W-1:0]       en_q;
  logic [NCH-1:0]        sc_chan_en;
  logic [NCH-1:0]        ck_chan_en;
  logic [NUM_SCALAR-1:0] w1c_scalar;
  logic [NCH-1:0]        w1c_short;
  logic [NCH-1:0]        w1c_clk;
  logic                  rdclr_inj;
  logic                  rdclr_reg;
  logic [NUM_SCALAR-1:0] rdclr_vec;

  // short-circuit events are masked by the per-channel detector enable
  assign set_vec = {evt_clkloss_i,
                    evt_short_i & sc_chan_en,
                    evt_wdog_i, evt_reg_ovr_i, evt_inj_ovr_i,
                    evt_reg_done_i, evt_inj_done_i};

  always_comb begin
    rdclr_vec               = '0;
    rdclr_vec[IDX_INJ_DONE] = rdclr_inj;
    rdclr_vec[IDX_REG_DONE] = rdclr_reg;
  end

  assign clr_vec = {w1c_clk, w1c_short, w1c_scalar | rdclr_vec};

  fltirq_flags #(.W(NF)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .flag_q (flags_q)
  );

  fltirq_regs #(.NCH(NCH), .DW(DW), .BW(BW)) u_regs (
    .clk            (clk),
    .rst_n          (rst_n),
    .addr_i         (bus_addr_i),
    .wr_i           (bus_wr_i),
    .wdata_i        (bus_wdata_i),
    .rd_i           (bus_rd_i),
    .scalar_flags_i (flags_q[0 +: NUM_SCALAR]),
    .short_flags_i  (flags_q[SC_BASE +: NCH]),
    .clk_flags_i    (flags_q[CK_BASE +: NCH]),
    .inj_data_i     (inj_data_i),
    .reg_data_i     (reg_data_i),
    .en_q           (en_q),
    .sc_chan_en_q   (sc_chan_en),
    .ck_chan_en_q   (ck_chan_en),
    .w1c_scalar     (w1c_scalar),
    .w1c_short      (w1c_short),
    .w1c_clk        (w1c_clk),
    .rdclr_inj      (rdclr_inj),
    .rdclr_reg      (rdclr_reg),
    .rdata_q        (bus_rdata_o),
    .rvalid_q       (bus_rvalid_o)
  );

  fltirq_irq #(.NCH(NCH)) u_irq (
    .clk          (clk),
    .rst_n        (rst_n),
    .flags_i      (flags_q),
    .en_i         (en_q),
    .ck_chan_en_i (ck_chan_en),
    .irq_q        (irq_o)
  );
endmodule

// File: rtl/fltirq_ctrl_chk.sv
module fltirq_ctrl_chk
  import fltirq_pkg::*;
#(
  parameter int unsigned NCH = 8,
  localparam int unsigned NF = NUM_SCALAR + 2 * NCH
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_wr_i,
  input logic              clr_inj_ovr_bit,
  input logic              bus_rd_i,
  input logic              bus_rvalid_o,
  input logic              irq_o,
  input logic              evt_inj_done_i,
  input logic              evt_reg_done_i,
  input logic              evt_inj_ovr_i,
  input logic              evt_reg_ovr_i,
  input logic              evt_wdog_i,
  input logic [NCH-1:0]    evt_short_i,
  input logic [NCH-1:0]    evt_clkloss_i,
  input logic [NCH-1:0]    sc_chan_en,
  input logic [NF-1:0]     flags
);
  logic [NCH-1:0] short_now;
  logic           any_evt;
  assign short_now = flags[NUM_SCALAR +: NCH];
  assign any_evt = evt_inj_done_i | evt_reg_done_i | evt_inj_ovr_i |
                   evt_reg_ovr_i | evt_wdog_i | (|evt_short_i) | (|evt_clkloss_i);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_inj_ovr_i |=> flags[IDX_INJ_OVR]);

  p_ovr_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[IDX_INJ_OVR] && !(bus_wr_i && bus_addr_i == A_CLEAR && clr_inj_ovr_bit))
    |=> flags[IDX_INJ_OVR]);

  p_read_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[IDX_INJ_DONE] && bus_rd_i && bus_addr_i == A_INJ_DATA && !evt_inj_done_i)
    |=> !flags[IDX_INJ_DONE]);

  p_short_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (short_now & ~$past(short_now) & ~$past(evt_short_i & sc_chan_en)) == '0);

  p_status_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_i && bus_addr_i == A_STATUS && !bus_wr_i && !any_evt) |=> $stable(flags));

  p_rvalid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_i |=> bus_rvalid_o);

  p_no_rvalid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_i |=> !bus_rvalid_o);

  p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(|flags));
endmodule

bind fltirq_ctrl fltirq_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .bus_addr_i      (bus_addr_i),
  .bus_wr_i        (bus_wr_i),
  .clr_inj_ovr_bit (bus_wdata_i[2]),
  .bus_rd_i        (bus_rd_i),
  .bus_rvalid_o    (bus_rvalid_o),
  .irq_o           (irq_o),
  .evt_inj_done_i  (evt_inj_done_i),
  .evt_reg_done_i  (evt_reg_done_i),
  .evt_inj_ovr_i   (evt_inj_ovr_i),
  .evt_reg_ovr_i   (evt_reg_ovr_i),
  .evt_wdog_i      (evt_wdog_i),
  .evt_short_i     (evt_short_i),
  .evt_clkloss_i   (evt_clkloss_i),
  .sc_chan_en      (sc_chan_en),
  .flags           (flags_q)
);

// File: tb/fltirq_ctrl_test.sv
module fltirq_ctrl_test;
  import fltirq_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam int DW  = 24;
  localparam int BW  = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evt_inj_done = 0, evt_reg_done = 0, evt_inj_ovr = 0, evt_reg_ovr = 0, evt_wdog = 0;
  logic [NCH-1:0] evt_short = '0, evt_clkloss = '0;
  logic [DW-1:0] inj_data = 24'h5A5A5A, reg_data = 24'h0C0FFE;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic bus_wr = 0, bus_rd = 0;
  logic [BW-1:0] bus_wdata = '0;
  logic [BW-1:0] bus_rdata;
  logic bus_rvalid, irq;

  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fltirq_ctrl #(.NCH(NCH), .DW(DW), .BW(BW)) uut (
    .clk(clk), .rst_n(rst_n),
    .evt_inj_done_i(evt_inj_done), .evt_reg_done_i(evt_reg_done),
    .evt_inj_ovr_i(evt_inj_ovr), .evt_reg_ovr_i(evt_reg_ovr), .evt_wdog_i(evt_wdog),
    .evt_short_i(evt_short), .evt_clkloss_i(evt_clkloss),
    .inj_data_i(inj_data), .reg_data_i(reg_data),
    .bus_addr_i(bus_addr), .bus_wr_i(bus_wr), .bus_wdata_i(bus_wdata), .bus_rd_i(bus_rd),
    .bus_rdata_o(bus_rdata), .bus_rvalid_o(bus_rvalid), .irq_o(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever read data comes back
  always @(negedge clk) begin : monitor
    logic [31:0] e;
    string t;
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        check("R11 rvalid without a read", 32'd1, 32'd0);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, bus_rdata, e);
      end
    end
  end

  task automatic rd(logic [ADDR_W-1:0] a, logic [31:0] exp, string tag);
    @(posedge clk); #1;
    bus_addr = a; bus_rd = 1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(posedge clk); #1;
    bus_rd = 0;
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk); #1;
    bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic ev(logic id, logic rdn, logic io, logic ro, logic wd,
                    logic [NCH-1:0] sc, logic [NCH-1:0] ck);
    @(posedge clk); #1;
    evt_inj_done = id; evt_reg_done = rdn; evt_inj_ovr = io; evt_reg_ovr = ro;
    evt_wdog = wd; evt_short = sc; evt_clkloss = ck;
    @(posedge clk); #1;
    evt_inj_done = 0; evt_reg_done = 0; evt_inj_ovr = 0; evt_reg_ovr = 0;
    evt_wdog = 0; evt_short = '0; evt_clkloss = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    idle(3);
    check("R1 irq in reset", {31'd0, irq}, 32'd0);
    check("R1 rvalid in reset", {31'd0, bus_rvalid}, 32'd0);
    @(posedge clk); #1 rst_n = 1;
    idle(1);
    rd(A_STATUS, 32'h0, "R1 status after reset");
    rd(A_ENABLE, 32'h0, "R1 enable after reset");
    rd(A_CHAN_EN, 32'h0, "R1 chan_en after reset");

    // R11 register readback and zero reads
    wr(A_ENABLE, 32'hFFFF_FFFF);
    wr(A_CHAN_EN, 32'hFFFF_A55A);
    rd(A_ENABLE, 32'h0000_007F, "R11 enable readback");
    rd(A_CHAN_EN, 32'h0000_A55A, "R11 chan_en readback");
    rd(A_CLEAR, 32'h0, "R11 clear reads zero");
    rd(3'd7, 32'h0, "R11 unmapped reads zero");
    wr(A_ENABLE, 32'h0);
    wr(A_CHAN_EN, 32'h0);

    // R2 injected done, gated irq, clear-on-read
    ev(1, 0, 0, 0, 0, '0, '0);
    idle(1);
    check("R2 irq gated off", {31'd0, irq}, 32'd0);
    rd(A_STATUS, 32'h1, "R2 inj done flag");
    rd(A_STATUS, 32'h1, "R10 status read keeps flag");
    rd(A_INJ_DATA, 32'h005A5A5A, "R2 inj data value");
    rd(A_STATUS, 32'h0, "R2 flag cleared by data read");

    // R9 irq latency and drop
    wr(A_ENABLE, 32'h1);
    ev(1, 0, 0, 0, 0, '0, '0);
    check("R9 irq not yet", {31'd0, irq}, 32'd0);
    idle(1);
    check("R9 irq one cycle after flag", {31'd0, irq}, 32'd1);
    rd(A_INJ_DATA, 32'h005A5A5A, "R2 inj data read");
    check("R9 irq still high at clear edge", {31'd0, irq}, 32'd1);
    idle(1);
    check("R9 irq drops after clear", {31'd0, irq}, 32'd0);

    // R3 regular done
    wr(A_ENABLE, 32'h2);
    ev(0, 1, 0, 0, 0, '0, '0);
    idle(1);
    check("R3 irq from reg done", {31'd0, irq}, 32'd1);
    rd(A_STATUS, 32'h2, "R3 reg done flag");
    rd(A_REG_DATA, 32'h000C0FFE, "R3 reg data value");
    rd(A_STATUS, 32'h0, "R3 flag cleared by data read");
    idle(1);
    check("R3 irq dropped", {31'd0, irq}, 32'd0);
    wr(A_ENABLE, 32'h0);

    // R4 overruns, R10 zero writes
    ev(0, 0, 1, 1, 0, '0, '0);
    rd(A_INJ_DATA, 32'h005A5A5A, "R4 data read");
    rd(A_REG_DATA, 32'h000C0FFE, "R4 data read");
    rd(A_STATUS, 32'hC, "R4 overruns survive data reads");
    wr(A_CLEAR, 32'h4);
    rd(A_STATUS, 32'h8, "R4 inj overrun cleared alone");
    wr(A_CLEAR, 32'h0);
    rd(A_STATUS, 32'h8, "R10 zero clear write");
    wr(A_CLEAR, 32'hFFFF_FFF7);
    rd(A_STATUS, 32'h8, "R10 zero in clear bit 3");
    wr(A_ENABLE, 32'h8);
    idle(1);
    check("R4 reg overrun irq", {31'd0, irq}, 32'd1);
    wr(A_CLEAR, 32'h8);
    rd(A_STATUS, 32'h0, "R4 reg overrun cleared");
    check("R4 irq dropped", {31'd0, irq}, 32'd0);
    wr(A_ENABLE, 32'h0);

    // R5 watchdog
    ev(0, 0, 0, 0, 1, '0, '0);
    idle(1);
    check("R5 irq gated off", {31'd0, irq}, 32'd0);
    rd(A_STATUS, 32'h10, "R5 watchdog flag");
    wr(A_ENABLE, 32'h10);
    check("R9 irq waits for enable edge", {31'd0, irq}, 32'd0);
    idle(1);
    check("R5 irq with enable", {31'd0, irq}, 32'd1);
    wr(A_CLEAR, 32'h10);
    idle(1);
    check("R5 irq dropped", {31'd0, irq}, 32'd0);
    rd(A_STATUS, 32'h0, "R5 watchdog cleared");
    wr(A_ENABLE, 32'h0);

    // R6 short-circuit
    wr(A_CHAN_EN, 32'h0000_000F);
    ev(0, 0, 0, 0, 0, 8'hF0, '0);
    rd(A_STATUS, 32'h0, "R6 disabled channels ignored");
    ev(0, 0, 0, 0, 0, 8'h05, '0);
    rd(A_STATUS, 32'h0000_0500, "R6 short channel flags");
    wr(A_ENABLE, 32'h20);
    check("R6 irq not yet", {31'd0, irq}, 32'd0);
    idle(1);
    check("R6 irq with short enable", {31'd0, irq}, 32'd1);
    wr(A_CLEAR, 32'h0000_0100);
    rd(A_STATUS, 32'h0000_0400, "R6 channel 0 cleared alone");
    check("R6 irq held by channel 2", {31'd0, irq}, 32'd1);
    wr(A_CLEAR, 32'h0000_0400);
    check("R9 irq high at clear edge", {31'd0, irq}, 32'd1);
    idle(1);
    check("R6 irq dropped", {31'd0, irq}, 32'd0);

    // R7 clock absence
    wr(A_ENABLE, 32'h40);
    wr(A_CHAN_EN, 32'h0000_F000);
    ev(0, 0, 0, 0, 0, 8'h01, 8'h01);
    idle(2);
    check("R7 channel 0 not enabled", {31'd0, irq}, 32'd0);
    rd(A_STATUS, 32'h0001_0000, "R7 flag set without enable, R6 short masked");
    ev(0, 0, 0, 0, 0, '0, 8'h10);
    check("R7 irq not yet", {31'd0, irq}, 32'd0);
    idle(1);
    check("R7 irq channel 4", {31'd0, irq}, 32'd1);
    wr(A_CLEAR, 32'h0011_0000);
    idle(2);
    check("R7 irq dropped", {31'd0, irq}, 32'd0);
    rd(A_STATUS, 32'h0, "R7 flags cleared");
    wr(A_ENABLE, 32'h0);

    // R8 set beats clear
    @(posedge clk); #1;
    evt_inj_ovr = 1; bus_addr = A_CLEAR; bus_wdata = 32'h4; bus_wr = 1;
    @(posedge clk); #1;
    evt_inj_ovr = 0; bus_wr = 0; bus_wdata = '0;
    rd(A_STATUS, 32'h4, "R8 set wins over clear write");
    @(posedge clk); #1;
    evt_inj_done = 1; bus_addr = A_INJ_DATA; bus_rd = 1;
    exp_q.push_back(32'h005A5A5A); tag_q.push_back("R8 data read");
    @(posedge clk); #1;
    evt_inj_done = 0; bus_rd = 0;
    rd(A_STATUS, 32'h5, "R8 set wins over data read");

    idle(3);
    check("R11 all reads answered", exp_q.size(), 32'd0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule